// File: doc/BRIEF.md
# Round-Robin Shared-Slave Bus Arbiter

This block decides which of several bus masters owns a single shared slave port. Each master drives a request line and a line that says a burst is still running. The arbiter serves requesting masters in rotating order. The master granted most recently drops to the lowest priority for the next decision, so no master can lock the others out.

When nobody requests, the grant is parked according to a two-bit policy input. The bus can be left ungranted, left with the master that owned it last, or handed to a master chosen by an index input. A programmable slot limit bounds how many consecutive cycles one master may keep the bus through a burst. When the limit runs out, the burst is broken and arbitration runs again.

The grant is registered. A decision is taken at each clock edge from the inputs present just before that edge, and it appears on the grant vector one cycle after the request.

Top module: `rr_bus_arbiter`

## Requirements
- R1: After reset the grant vector is all zero, `parked` is low, and the rotation pointer points at master 0, so master 0 has the highest priority in the first decision.
- R2: The grant vector is one-hot or zero in every cycle. A set grant bit with `parked` low belongs to a master whose request was high at the deciding edge.
- R3: In each decision the search starts at the master after the one granted last and wraps around. With every master requesting single transfers, the grants go 0,1,2,3,4,0.
- R4: When `slot_limit` is 0, the current owner keeps the grant as long as its request and burst lines are both high.
- R5: When `slot_limit` = L > 0, an owner whose burst continues holds the grant for at most L consecutive cycles per grant. After that a new decision is made in which the owner has the lowest priority. Each new grant reloads the full limit.
- R6: An owner whose burst line is low is at a transfer boundary in every cycle, so a new decision is made at the next edge.
- R7: With `park_mode` 0 (none) or 3 (reserved, treated as none), no request gives an all-zero grant with `parked` low.
- R8: With `park_mode` 1 (last owner), no request gives a grant to the master that most recently won arbitration, with `parked` high. If no master has won since reset, the grant is zero.
- R9: With `park_mode` 2 (fixed), no request gives a grant to master `park_idx`, with `parked` high. A `park_idx` of N_MASTERS or more gives a zero grant.
- R10: A parked grant does not move the rotation pointer. A parked master is not an owner and has to win arbitration through its request, after which `parked` drops.
- R11: The grant is registered. A request first shows on `gnt` after the next rising clock edge, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MASTERS | Request line, one per master |
| burst | input | N_MASTERS | Burst-in-progress line, one per master |
| park_mode | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed, 3 none |
| park_idx | input | IDX_W | Master index used by the fixed idle policy |
| slot_limit | input | SLOT_W | Maximum consecutive burst cycles per grant, 0 means unlimited |
| gnt | output | N_MASTERS | Grant vector, one-hot or zero |
| parked | output | 1 | High when the grant is an idle-policy park and not an arbitration win |

## Verification
Some properties are checked on every cycle by assertions. The grant stays one-hot or zero. A non-parked grant goes only to a master that was requesting. An unlimited-slot owner keeps the bus while its burst continues. An expired slot forces a new grant with the counter reloaded. A parked cycle leaves the rotation pointer unchanged, and the "none" policy grants nothing to an idle bus. Other behaviour only the directed scenarios can show: the actual rotation order across sparse request patterns, the exact number of cycles a burst is held before it is broken, which master each idle policy picks, and the one-cycle grant latency.

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
  parameter int N_MASTERS = 5,
  parameter int SLOT_W    = 8,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] burst,
  input  logic [1:0]           park_mode,
  input  logic [IDX_W-1:0]     park_idx,
  input  logic [SLOT_W-1:0]    slot_limit,
  output logic [N_MASTERS-1:0] gnt,
  output logic                 parked
);

  localparam logic [N_MASTERS-1:0] ONE = {{(N_MASTERS-1){1'b0}}, 1'b1};

  logic [N_MASTERS-1:0] gnt_q;
  logic                 parked_q;
  logic [IDX_W-1:0]     own_q;
  logic                 have_own;
  logic [IDX_W-1:0]     rr_ptr;
  logic [SLOT_W-1:0]    slot_cnt;

  logic             active, expire, hold;
  logic             win_ok, park_ok;
  logic [IDX_W-1:0] win_idx, park_sel;

  assign gnt    = gnt_q;
  assign parked = parked_q;

  assign active = (gnt_q != '0) && !parked_q;
  assign expire = (slot_limit != '0) && (slot_cnt == SLOT_W'(1));
  assign hold   = active && req[own_q] && burst[own_q] && !expire;

  always_comb begin
    int c;
    win_ok  = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      c = int'(rr_ptr) + i;
      if (c >= N_MASTERS) c = c - N_MASTERS;
      if (!win_ok && req[c]) begin
        win_ok  = 1'b1;
        win_idx = IDX_W'(c);
      end
    end
  end

  always_comb begin
    park_ok  = 1'b0;
    park_sel = '0;
    case (park_mode)
      2'd1: begin
        park_ok  = have_own;
        park_sel = own_q;
      end
      2'd2: begin
        park_ok  = (int'(park_idx) < N_MASTERS);
        park_sel = park_idx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q    <= '0;
      parked_q <= 1'b0;
      own_q    <= '0;
      have_own <= 1'b0;
      rr_ptr   <= '0;
      slot_cnt <= '0;
    end else if (hold) begin
      slot_cnt <= slot_cnt - SLOT_W'(1);
    end else if (win_ok) begin
      gnt_q    <= ONE << win_idx;
      parked_q <= 1'b0;
      own_q    <= win_idx;
      have_own <= 1'b1;
      rr_ptr   <= (int'(win_idx) == N_MASTERS - 1) ? '0 : win_idx + IDX_W'(1);
      slot_cnt <= slot_limit;
    end else if (park_ok) begin
      gnt_q    <= ONE << park_sel;
      parked_q <= 1'b1;
    end else begin
      gnt_q    <= '0;
      parked_q <= 1'b0;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  a_r2_gnt_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (parked_q || ((gnt_q & ~$past(req)) == '0)));

  a_r4_unlimited_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot_limit == '0 && (gnt_q & req & burst) != '0) |=> $stable(gnt_q));

  a_r5_slot_break: assert property (@(posedge clk) disable iff (!rst_n)
    (active && expire && (gnt_q & req & burst) != '0)
      |=> (!parked_q && slot_cnt == $past(slot_limit)));

  a_r7_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && (park_mode == 2'd0 || park_mode == 2'd3)) |=> (gnt_q == '0 && !parked_q));

  a_r10_park_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && req == '0) |=> $stable(rr_ptr));

endmodule

// File: tb/rr_bus_arbiter_tb.sv
module rr_bus_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] req, burst;
  logic [1:0] park_mode;
  logic [2:0] park_idx;
  logic [7:0] slot_limit;
  logic [4:0] gnt;
  logic       parked;

  int vectors = 0;
  int errs    = 0;

  always #4 clk = ~clk;

  rr_bus_arbiter #(.N_MASTERS(5), .SLOT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst),
    .park_mode(park_mode), .park_idx(park_idx), .slot_limit(slot_limit),
    .gnt(gnt), .parked(parked)
  );

  task automatic chk(input string r, input logic [4:0] act, input logic [4:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; burst = '0; park_mode = 2'd0; park_idx = '0; slot_limit = '0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 gnt", gnt, 5'b0);
    chk("R1 parked", {4'b0, parked}, 5'b0);
  endtask

  task automatic t_rr_all();
    logic [4:0] exp [6] = '{5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000, 5'b00001};
    do_reset();
    req = 5'b11111;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R3 R6 rotation", gnt, exp[i]);
    end
  endtask

  task automatic t_rr_sparse();
    logic [4:0] exp [3] = '{5'b00010, 5'b10000, 5'b00010};
    do_reset();
    req = 5'b10010;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 R3 sparse", gnt, exp[i]);
    end
  endtask

  task automatic t_burst_hold();
    do_reset();
    req = 5'b11111; burst = 5'b00001;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R4 hold", gnt, 5'b00001);
    end
    burst = '0;
    tick();
    chk("R6 burst end", gnt, 5'b00010);
  endtask

  task automatic t_slot();
    logic [4:0] exp [7] = '{5'b00001, 5'b00001, 5'b00001, 5'b00010, 5'b00010, 5'b00010, 5'b00100};
    do_reset();
    slot_limit = 8'd3; req = 5'b11111; burst = 5'b11111;
    for (int i = 0; i < 7; i++) begin
      tick();
      chk("R5 slot break", gnt, exp[i]);
    end
  endtask

  task automatic t_slot_reload();
    do_reset();
    slot_limit = 8'd2; req = 5'b00010; burst = 5'b00010;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R5 R2 lone regrant", gnt, 5'b00010);
      chk("R5 not parked", {4'b0, parked}, 5'b0);
    end
  endtask

  task automatic t_park_none();
    do_reset();
    req = 5'b00100;
    tick();
    chk("R7 grant", gnt, 5'b00100);
    req = '0;
    tick();
    chk("R7 idle none", gnt, 5'b0);
    chk("R7 parked", {4'b0, parked}, 5'b0);
    park_mode = 2'd3;
    tick();
    chk("R7 mode3", gnt, 5'b0);
  endtask

  task automatic t_park_last();
    do_reset();
    park_mode = 2'd1;
    tick();
    chk("R8 no owner yet", gnt, 5'b0);
    req = 5'b00100;
    tick();
    chk("R8 grant", gnt, 5'b00100);
    req = '0;
    tick();
    chk("R8 park last", gnt, 5'b00100);
    chk("R8 parked", {4'b0, parked}, 5'b00001);
    tick();
    chk("R8 park stays", gnt, 5'b00100);
    req = 5'b11111;
    tick();
    chk("R10 ptr kept", gnt, 5'b01000);
    chk("R10 parked low", {4'b0, parked}, 5'b0);
  endtask

  task automatic t_park_fixed();
    do_reset();
    park_mode = 2'd2; park_idx = 3'd3;
    tick();
    chk("R9 fixed", gnt, 5'b01000);
    chk("R9 parked", {4'b0, parked}, 5'b00001);
    park_idx = 3'd7;
    tick();
    chk("R9 out of range", gnt, 5'b0);
    park_idx = 3'd3;
    tick();
    chk("R9 fixed again", gnt, 5'b01000);
    req = 5'b01000;
    tick();
    chk("R10 win from park", gnt, 5'b01000);
    chk("R10 parked drops", {4'b0, parked}, 5'b0);
  endtask

  task automatic t_latency();
    do_reset();
    req = 5'b00001;
    #1;
    chk("R11 no same-cycle grant", gnt, 5'b0);
    tick();
    chk("R11 grant next edge", gnt, 5'b00001);
  endtask

  initial begin
    t_reset();
    t_rr_all();
    t_rr_sparse();
    t_burst_hold();
    t_slot();
    t_slot_reload();
    t_park_none();
    t_park_last();
    t_park_fixed();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule